// File: doc/BRIEF.md
# Non-Volatile Memory Command Register Front End

This block sits behind a management register bus that has already been decoded to a register index, a write strobe, a read strobe and data. It holds the settings for a transfer to or from a serial EEPROM: a control word with a direction bit and an operation code, a device address, a memory address, an address-width mode bit, and a read-back byte. When software writes a valid operation code while the block is idle, the block issues one request to an external I2C master. The request is either a single-byte transfer or a whole-memory transfer. It then tracks the outcome in a two-bit status field.

The status is sticky. A finished command keeps reporting success or failure until software reads the control register. The field returns to idle only after that read. While the status is anything but idle, every write to the configuration registers is discarded. This means the request fields cannot change under a transfer. After a hardware reset, or after a pulse on the synchronous soft reset input, the block launches a whole-memory read by itself if the boot-enable input is high.

The request to the master is a valid/ready port. `req_valid` and every `req_*` field stay constant until the master raises `req_ready`, so the master may hold off for as long as it needs. The outcome comes back as a one-cycle `xfer_done` or `xfer_fail` pulse, which counts only after the request has been accepted. The register bus itself has no back-pressure. A write takes effect at the next edge. Read data is combinational from `reg_addr` while `reg_rd` is high.

Top module: `nvr_cmd_regs`

## Requirements
- R1: After reset with `boot_en` low, the registers hold these values and `req_valid` is 0:
  - control reads 0x0003;
  - device address reads 0x00A2;
  - memory address reads 0x0000;
  - read-back reads 0x0000;
  - mode reads 0x0000.
- R2: The register indices are: control = 0, device address = 1, memory address = 2, read-back = 3, mode = 4. The control word carries direction in bit 5 (1 = write to memory, 0 = read from memory), status in bits 3:2 and the operation code in bits 1:0. Every other control bit reads as 0 whatever was written.
- R3: The operation code is 2'b10 for a single byte and 2'b11 for the whole memory. Writing control while idle with either code does two things at the next edge. It sets status to 2'b10 (busy). It raises `req_valid`, with `req_write` = direction, `req_all` = 1 for 2'b11, and the device and memory addresses. `req_valid` and these fields then hold until a cycle with `req_ready` high.
- R4: While busy, the outcome is taken only after the request has been accepted. Before acceptance, `xfer_done` is ignored. After acceptance, `xfer_done` sets status to 2'b01 (success) and `xfer_fail` sets it to 2'b11 (failed). If both arrive in the same cycle, failure wins.
- R5: A success or failed status holds until the control register is read. That read returns the status, and the field reads 2'b00 (idle) from the next cycle on.
- R6: Writes to the control, device address, memory address and mode registers are discarded while status is not idle.
- R7: A control write with operation code 2'b00 or 2'b01 is stored and reads back, but it starts no request and status stays idle.
- R8: Bit 0 of the device address is always 0. It cannot be set by a write.
- R9: Mode bit 0 = 1 presents all 16 memory address bits on `req_mem`. With mode bit 0 = 0, `req_mem[15:8]` is 0 and only bits 7:0 are used.
- R10: A successful single-byte read loads `xfer_rdata` into bits 7:0 of the read-back register, and bits 15:8 read as 0. A successful write or whole-memory transfer leaves the read-back register unchanged, and so does a failed transfer.
- R11: Suppose `boot_en` is high at the end of a hardware reset or of a `soft_rst` pulse. On the first edge after the reset, the block sets direction to read and the operation code to 2'b11, and issues a whole-memory read request, so control reads 0x000B. A `soft_rst` pulse also returns every register to its R1 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous reset pulse with the same effect as reset |
| boot_en | input | 1 | Enables the automatic whole-memory read after reset |
| reg_addr | input | 3 | Decoded register index |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of control clears a finished status |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational |
| req_valid | output | 1 | Transfer request pending |
| req_ready | input | 1 | Master accepts the request |
| req_write | output | 1 | 1 = write to memory, 0 = read from memory |
| req_all | output | 1 | 1 = whole memory, 0 = single byte |
| req_dev | output | 8 | Device address, always even |
| req_mem | output | 16 | Memory address, with the upper byte zeroed in narrow mode |
| xfer_done | input | 1 | Transfer finished successfully, one-cycle pulse |
| xfer_fail | input | 1 | Transfer failed, one-cycle pulse |
| xfer_rdata | input | 8 | Byte returned by a single-byte read |

## Verification
Read data is due in the same cycle as the read strobe. Register contents, status, `req_valid` and the request fields change one edge after the write, accept, done or fail cycle that causes them. A status cleared by a read reads idle on the next read strobe. Boot launch is visible one edge after reset is released. The bench drives every input on the falling edge and samples 2 ns later, so each read or port check lands one whole cycle after its cause. The scoreboard pairs every read strobe with the expected word that was queued just before it.

// File: rtl/nvr_cmd_pkg.sv
package nvr_cmd_pkg;
  localparam int REG_W  = 16;
  localparam int BYTE_W = 8;
  localparam int REG_AW = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_OK   = 2'b01,
    ST_BUSY = 2'b10,
    ST_FAIL = 2'b11
  } nvr_stat_e;

  localparam logic [1:0] OP_ONE = 2'b10;
  localparam logic [1:0] OP_ALL = 2'b11;

  localparam logic [REG_AW-1:0] A_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] A_DEV  = 3'd1;
  localparam logic [REG_AW-1:0] A_MEM  = 3'd2;
  localparam logic [REG_AW-1:0] A_DATA = 3'd3;
  localparam logic [REG_AW-1:0] A_MODE = 3'd4;

  localparam int DIR_BIT = 5;
endpackage

// File: rtl/nvr_cmd_fsm.sv
module nvr_cmd_fsm
  import nvr_cmd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      soft_rst,
  input  logic      launch,
  input  logic      rd_ctrl,
  input  logic      req_ready,
  input  logic      xfer_done,
  input  logic      xfer_fail,
  output nvr_stat_e status,
  output logic      req_valid,
  output logic      xfer_ok
);
  logic in_flight;

  // success in this cycle: only counts once the request was taken
  assign xfer_ok = (status == ST_BUSY) && in_flight && xfer_done && !xfer_fail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status    <= ST_IDLE;
      req_valid <= 1'b0;
      in_flight <= 1'b0;
    end else if (soft_rst) begin
      status    <= ST_IDLE;
      req_valid <= 1'b0;
      in_flight <= 1'b0;
    end else begin
      unique case (status)
        ST_IDLE: if (launch) begin
          status    <= ST_BUSY;
          req_valid <= 1'b1;
          in_flight <= 1'b0;
        end
        ST_BUSY: begin
          if (req_valid && req_ready) begin
            req_valid <= 1'b0;
            in_flight <= 1'b1;
          end
          if (in_flight && xfer_fail) begin
            status    <= ST_FAIL;
            in_flight <= 1'b0;
          end else if (in_flight && xfer_done) begin
            status    <= ST_OK;
            in_flight <= 1'b0;
          end
        end
        default: if (rd_ctrl) status <= ST_IDLE;
      endcase
    end
  end

  p_launch_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (status == ST_IDLE && launch && !soft_rst) |=> (status == ST_BUSY && req_valid));

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !soft_rst) |=> req_valid);

  p_result_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((status == ST_OK || status == ST_FAIL) && !rd_ctrl && !soft_rst) |=> $stable(status));

  p_read_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((status == ST_OK || status == ST_FAIL) && rd_ctrl && !soft_rst) |=> status == ST_IDLE);

  p_no_early_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (status == ST_BUSY && req_valid && !soft_rst) |=> status == ST_BUSY);
endmodule

// File: rtl/nvr_cmd_cfg.sv
module nvr_cmd_cfg
  import nvr_cmd_pkg::*;
#(
  parameter logic [BYTE_W-1:0] DEV_RESET = 8'hA2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              boot_en,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              idle,
  input  logic              cap_en,
  input  logic [BYTE_W-1:0] cap_data,
  output logic              boot_go,
  output logic              ctrl_wr,
  output logic              dir,
  output logic [1:0]        op,
  output logic [BYTE_W-2:0] dev_hi,
  output logic [REG_W-1:0]  mem,
  output logic              wide,
  output logic [BYTE_W-1:0] rbyte
);
  logic boot_pend;
  logic wr_ok;

  assign boot_go = boot_pend && boot_en;
  assign wr_ok   = wr_en && idle && !boot_pend;
  assign ctrl_wr = wr_ok && (wr_addr == A_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_pend <= 1'b1;
      dir       <= 1'b0;
      op        <= OP_ALL;
      dev_hi    <= DEV_RESET[BYTE_W-1:1];
      mem       <= '0;
      wide      <= 1'b0;
      rbyte     <= '0;
    end else if (soft_rst) begin
      boot_pend <= 1'b1;
      dir       <= 1'b0;
      op        <= OP_ALL;
      dev_hi    <= DEV_RESET[BYTE_W-1:1];
      mem       <= '0;
      wide      <= 1'b0;
      rbyte     <= '0;
    end else begin
      boot_pend <= 1'b0;
      if (boot_go) begin
        dir <= 1'b0;
        op  <= OP_ALL;
      end else if (wr_ok) begin
        unique case (wr_addr)
          A_CTRL: begin
            dir <= wr_data[DIR_BIT];
            op  <= wr_data[1:0];
          end
          A_DEV:  dev_hi <= wr_data[BYTE_W-1:1];
          A_MEM:  mem    <= wr_data;
          A_MODE: wide   <= wr_data[0];
          default: ;
        endcase
      end
      if (cap_en && !dir && op == OP_ONE) rbyte <= cap_data;
    end
  end

  p_write_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && wr_en && !soft_rst) |=> $stable({dir, op, dev_hi, mem, wide}));

  p_boot_read_all_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_go && !soft_rst) |=> (!dir && op == OP_ALL));
endmodule

// File: rtl/nvr_cmd_regs.sv
module nvr_cmd_regs
  import nvr_cmd_pkg::*;
#(
  parameter logic [BYTE_W-1:0] DEV_RESET = 8'hA2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              boot_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic              req_all,
  output logic [BYTE_W-1:0] req_dev,
  output logic [REG_W-1:0]  req_mem,
  input  logic              xfer_done,
  input  logic              xfer_fail,
  input  logic [BYTE_W-1:0] xfer_rdata
);
  nvr_stat_e         status;
  logic              boot_go, ctrl_wr, launch, rd_ctrl, xfer_ok;
  logic              dir, wide;
  logic [1:0]        op;
  logic [BYTE_W-2:0] dev_hi;
  logic [REG_W-1:0]  mem;
  logic [BYTE_W-1:0] rbyte;

  assign rd_ctrl = reg_rd && (reg_addr == A_CTRL);
  assign launch  = boot_go || (ctrl_wr && reg_wdata[1]);

  nvr_cmd_cfg #(.DEV_RESET(DEV_RESET)) u_cfg (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .boot_en(boot_en),
    .wr_en(reg_wr), .wr_addr(reg_addr), .wr_data(reg_wdata),
    .idle(status == ST_IDLE), .cap_en(xfer_ok), .cap_data(xfer_rdata),
    .boot_go(boot_go), .ctrl_wr(ctrl_wr), .dir(dir), .op(op),
    .dev_hi(dev_hi), .mem(mem), .wide(wide), .rbyte(rbyte)
  );

  nvr_cmd_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .launch(launch),
    .rd_ctrl(rd_ctrl), .req_ready(req_ready), .xfer_done(xfer_done),
    .xfer_fail(xfer_fail), .status(status), .req_valid(req_valid),
    .xfer_ok(xfer_ok)
  );

  assign req_write = dir;
  assign req_all   = (op == OP_ALL);
  assign req_dev   = {dev_hi, 1'b0};
  assign req_mem   = wide ? mem : {{(REG_W-BYTE_W){1'b0}}, mem[BYTE_W-1:0]};

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_CTRL: begin
        reg_rdata[DIR_BIT] = dir;
        reg_rdata[3:2]     = status;
        reg_rdata[1:0]     = op;
      end
      A_DEV:  reg_rdata[BYTE_W-1:0] = {dev_hi, 1'b0};
      A_MEM:  reg_rdata = mem;
      A_DATA: reg_rdata[BYTE_W-1:0] = rbyte;
      A_MODE: reg_rdata[0] = wide;
      default: ;
    endcase
  end

  p_reserved_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_CTRL && status == ST_IDLE && !reg_wdata[1] && !boot_go && !soft_rst)
      |=> (status == ST_IDLE && !req_valid));

  p_req_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !soft_rst) |=> $stable({req_write, req_all, req_dev, req_mem}));
endmodule

// File: tb/nvr_cmd_regs_test.sv
`timescale 1ns/1ps
module nvr_cmd_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0, soft_rst = 1'b0, boot_en = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        req_valid, req_write, req_all;
  logic        req_ready = 1'b0;
  logic [7:0]  req_dev;
  logic [15:0] req_mem;
  logic        xfer_done = 1'b0, xfer_fail = 1'b0;
  logic [7:0]  xfer_rdata = '0;

  int nchk = 0, nbad = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  nvr_cmd_regs uut (.*);

  task automatic pchk(string tag, logic [15:0] act, logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected word for every read strobe
  always @(negedge clk) begin
    #2;
    if (reg_rd) begin
      if (exp_q.size() == 0) pchk("scoreboard-empty", reg_rdata, 16'hxxxx);
      else pchk(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
    end
  end

  task automatic rd(logic [2:0] a, logic [15:0] e, string tag);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    #2;
  endtask

  task automatic accept();
    @(negedge clk); req_ready = 1'b1;
    @(negedge clk); req_ready = 1'b0;
    #2;
  endtask

  task automatic finish_xfer(logic d, logic f, logic [7:0] b);
    @(negedge clk); xfer_done = d; xfer_fail = f; xfer_rdata = b;
    @(negedge clk); xfer_done = 1'b0; xfer_fail = 1'b0;
  endtask

  task automatic hw_reset(logic be);
    boot_en = be; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    nchk++; nbad++;
    $display("FAIL watchdog: act=running exp=finished");
    report();
  end

  initial begin
    hw_reset(1'b0);
    rd(3'd0, 16'h0003, "R1 ctrl reset");
    rd(3'd1, 16'h00A2, "R1 dev reset");
    rd(3'd2, 16'h0000, "R1 mem reset");
    rd(3'd3, 16'h0000, "R1 rdata reset");
    rd(3'd4, 16'h0000, "R1 mode reset");
    pchk("R1 req_valid idle", {15'd0, req_valid}, 16'h0000);

    wr(3'd1, 16'h0051);
    rd(3'd1, 16'h0050, "R8 dev bit0 forced");
    wr(3'd2, 16'h1234);

    // single-byte write, narrow addressing
    wr(3'd0, 16'h0022);
    pchk("R3 req_valid", {15'd0, req_valid}, 16'h0001);
    pchk("R3 req_write", {15'd0, req_write}, 16'h0001);
    pchk("R3 req_all", {15'd0, req_all}, 16'h0000);
    pchk("R3 req_dev", {8'd0, req_dev}, 16'h0050);
    pchk("R9 narrow req_mem", req_mem, 16'h0034);
    rd(3'd0, 16'h002A, "R3 busy status");
    finish_xfer(1'b1, 1'b0, 8'h00);
    rd(3'd0, 16'h002A, "R4 done before accept ignored");
    pchk("R3 req_valid held", {15'd0, req_valid}, 16'h0001);
    wr(3'd1, 16'h0010);
    wr(3'd0, 16'h0003);
    rd(3'd1, 16'h0050, "R6 dev write while busy");
    accept();
    pchk("R3 req dropped after accept", {15'd0, req_valid}, 16'h0000);
    finish_xfer(1'b1, 1'b0, 8'hEE);
    wr(3'd2, 16'hFFFF);
    repeat (3) @(negedge clk);
    rd(3'd0, 16'h0026, "R5 success held");
    rd(3'd0, 16'h0022, "R5 cleared after read");
    rd(3'd2, 16'h1234, "R6 mem write while done");
    rd(3'd3, 16'h0000, "R10 write leaves rdata");

    // single-byte read, wide addressing
    wr(3'd4, 16'h0001);
    wr(3'd0, 16'h0002);
    pchk("R9 wide req_mem", req_mem, 16'h1234);
    pchk("R3 read dir", {15'd0, req_write}, 16'h0000);
    accept();
    finish_xfer(1'b1, 1'b0, 8'h5A);
    rd(3'd3, 16'h005A, "R10 read byte captured");
    rd(3'd0, 16'h0006, "R4 success status");
    rd(3'd0, 16'h0002, "R5 idle after read");

    // whole memory, done and fail together
    wr(3'd0, 16'h0003);
    pchk("R3 req_all", {15'd0, req_all}, 16'h0001);
    accept();
    finish_xfer(1'b1, 1'b1, 8'h77);
    rd(3'd0, 16'h000F, "R4 fail wins");
    rd(3'd3, 16'h005A, "R10 failed leaves rdata");
    rd(3'd0, 16'h0003, "R5 fail cleared");

    // reserved codes
    wr(3'd0, 16'h0021);
    pchk("R7 no request", {15'd0, req_valid}, 16'h0000);
    rd(3'd0, 16'h0021, "R7 reserved stored idle");
    wr(3'd0, 16'hFFD0);
    rd(3'd0, 16'h0000, "R2 reserved bits zero");

    // soft reset boot
    boot_en = 1'b1;
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    rd(3'd0, 16'h000B, "R11 soft boot busy");
    pchk("R11 boot req_all", {15'd0, req_all}, 16'h0001);
    pchk("R11 boot read", {15'd0, req_write}, 16'h0000);
    rd(3'd1, 16'h00A2, "R11 soft dev restored");
    rd(3'd4, 16'h0000, "R11 soft mode restored");
    accept();
    finish_xfer(1'b1, 1'b0, 8'h11);
    rd(3'd0, 16'h0007, "R11 boot success");
    rd(3'd0, 16'h0003, "R5 boot cleared");
    rd(3'd3, 16'h0000, "R10 all read leaves rdata");

    // hardware reset boot
    hw_reset(1'b1);
    rd(3'd0, 16'h000B, "R11 hw boot busy");
    pchk("R11 hw req_valid", {15'd0, req_valid}, 16'h0001);

    repeat (4) @(negedge clk);
    pchk("scoreboard drained", 16'(exp_q.size()), 16'h0000);
    report();
  end
endmodule